// File: doc/BRIEF.md
# Sync Pulse Low-Time Analyzer

This block measures how long the low phase of a positive-polarity horizontal sync-type signal lasts. Firmware uses the figure to estimate the incoming line period or to size a stretched vertical pulse. One of two asynchronous inputs is measured: the sync output (`src_sel` = 0) or the flyback signal (`src_sel` = 1). The selected signal passes through a two-flop synchronizer and an edge detector. A down-counter then runs at four counts per microsecond over the low phase.

Software writes 1 to the acquire bit (`acq_wr` with `acq_wdata` = 1), which makes `acq_busy` go high. The block waits for the next falling edge, counts down from 255 until the following rising edge, and then loads `low_result`, clears `acq_busy` and pulses `meas_done`. The low time in microseconds is (256 − result) / 4. The counter stops at 0, so the largest value that can be reported is 64 µs. The tick rate comes from a prescaler: `TICK_DIV` system clocks make one quarter microsecond. The prescaler restarts on the falling edge that opens a measurement. Writing 0 to the acquire bit during a measurement aborts it.

The controller has three states. IDLE: no measurement is pending. ARM: the acquire bit is set and the block waits for a falling edge. COUNT: the low phase is being timed. The transitions are:
- START: IDLE→ARM, on a write of 1.
- FALL: ARM→COUNT, on a falling edge.
- RISE: COUNT→IDLE, on a rising edge; this completes the measurement.
- ABORT: ARM→IDLE or COUNT→IDLE, on a write of 0.

Top module: `sync_low_timer`

## Requirements
- R1: After reset, `acq_busy` = 0, `meas_done` = 0 and `low_result` = 0.
- R2: A write of 1 while idle raises `acq_busy` on the next clock edge.
- R3: Timing starts only at the first falling edge seen after arming. A low phase already in progress when the bit is set, and the rise that ends it, are ignored.
- R4: For a low phase of L system clocks, the result is 255 − floor((L−1)/TICK_DIV). There is one decrement for every TICK_DIV clocks after the falling edge.
- R5: The counter saturates at 0 and never wraps. Any low phase with floor((L−1)/TICK_DIV) ≥ 255 reports 0, which is 64 µs.
- R6: Completion happens on a single clock edge. On the third clock edge after the selected input rises, `low_result` loads, `acq_busy` falls and `meas_done` goes high for exactly one cycle.
- R7: `src_sel` = 0 measures `hsync_in` and `src_sel` = 1 measures `flyback_in`. Activity on the other input has no effect.
- R8: A write of 0 while busy drops `acq_busy` on the next edge, produces no `meas_done`, and leaves `low_result` unchanged. An abort takes precedence over a rising edge in the same cycle.
- R9: A write of 1 while busy has no effect on the running measurement.
- R10: `low_result` changes only in the cycle in which `meas_done` is high.
- R11: While idle, neither a write of 0 nor input edges make the block busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | 0 = sync output, 1 = flyback |
| hsync_in | input | 1 | Asynchronous sync output signal |
| flyback_in | input | 1 | Asynchronous flyback signal |
| acq_wr | input | 1 | Single-cycle write strobe for the acquire bit |
| acq_wdata | input | 1 | Value written to the acquire bit |
| acq_busy | output | 1 | Acquire bit as read back by software |
| low_result | output | 8 | Last completed down-count |
| meas_done | output | 1 | One-cycle completion pulse |

## Verification
`acq_busy` answers a write one clock edge later. A completion follows the selected input's rise by three edges: two synchronizer stages and then the state register. The bench drives every input on the falling clock edge and counts negative edges from each stimulus. It reads `acq_busy`, `meas_done` and `low_result` exactly three negedges after raising the input, and checks `meas_done` low one negedge later. A sweep of low-phase lengths runs against the arithmetic R4/R5 formula, including the lengths on either side of saturation.

// File: rtl/slt_pkg.sv
package slt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } slt_state_e;
endpackage

// File: rtl/slt_edge_sync.sv
module slt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_sel,
    input  logic sync_raw,
    input  logic fb_raw,
    output logic fall_det,
    output logic rise_det
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw;
    logic [NCH-1:0] synced;
    logic           lvl;
    logic           lvl_q;

    assign raw = {fb_raw, sync_raw};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[STAGES-2:0], raw[c]};
            end
            assign synced[c] = sh[STAGES-1];
        end
    endgenerate

    assign lvl = src_sel ? synced[1] : synced[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

    assign fall_det = lvl_q & ~lvl;
    assign rise_det = ~lvl_q & lvl;
endmodule

// File: rtl/slt_tick_gen.sv
module slt_tick_gen #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (clr)          cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl
    import slt_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_val,
    input  logic             fall,
    input  logic             rise,
    input  logic             tick,
    output logic             presc_clr,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             done
);
    localparam logic [RES_W-1:0] CNT_TOP = '1;

    slt_state_e state, state_nx;
    logic [RES_W-1:0] cnt;
    logic start_req, abort_req, complete, open_cnt;

    assign start_req = wr & wr_val;
    assign abort_req = wr & ~wr_val;
    assign open_cnt  = (state == ST_ARM) & fall & ~abort_req;
    assign complete  = (state == ST_COUNT) & rise & ~abort_req;
    assign presc_clr = open_cnt;
    assign busy      = (state != ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_req) state_nx = ST_ARM;
            ST_ARM: begin
                if (abort_req)  state_nx = ST_IDLE;
                else if (fall)  state_nx = ST_COUNT;
            end
            ST_COUNT: begin
                if (abort_req)  state_nx = ST_IDLE;
                else if (rise)  state_nx = ST_IDLE;
            end
            default:            state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= CNT_TOP;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= complete;
            if (complete) result <= cnt;
            if (open_cnt)
                cnt <= CNT_TOP;
            else if ((state == ST_COUNT) && tick && (cnt != '0))
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sync_low_timer.sv
module sync_low_timer #(
    parameter int TICK_DIV    = 25,
    parameter int RES_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             hsync_in,
    input  logic             flyback_in,
    input  logic             acq_wr,
    input  logic             acq_wdata,
    output logic             acq_busy,
    output logic [RES_W-1:0] low_result,
    output logic             meas_done
);
    logic fall_det, rise_det, tick, presc_clr;

    slt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .sync_raw (hsync_in),
        .fb_raw   (flyback_in),
        .fall_det (fall_det),
        .rise_det (rise_det)
    );

    slt_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (presc_clr),
        .tick  (tick)
    );

    slt_ctrl #(.RES_W(RES_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (acq_wr),
        .wr_val    (acq_wdata),
        .fall      (fall_det),
        .rise      (rise_det),
        .tick      (tick),
        .presc_clr (presc_clr),
        .busy      (acq_busy),
        .result    (low_result),
        .done      (meas_done)
    );
endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acq_wr,
    input logic             acq_wdata,
    input logic             acq_busy,
    input logic [RES_W-1:0] low_result,
    input logic             meas_done
);
    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_busy && acq_wr && acq_wdata) |=> acq_busy);

    assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> (!acq_busy && $past(acq_busy)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> !meas_done);

    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_busy && acq_wr && !acq_wdata) |=> (!acq_busy && !meas_done));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_done |-> $stable(low_result));

    assert_idle_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_busy && !(acq_wr && acq_wdata)) |=> !acq_busy);
endmodule

bind sync_low_timer slt_checker #(.RES_W(RES_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_wr     (acq_wr),
    .acq_wdata  (acq_wdata),
    .acq_busy   (acq_busy),
    .low_result (low_result),
    .meas_done  (meas_done)
);

// File: tb/sync_low_timer_tb_top.sv
module sync_low_timer_tb_top;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_sel = 1'b0;
    logic hsync_in = 1'b1;
    logic flyback_in = 1'b1;
    logic acq_wr = 1'b0;
    logic acq_wdata = 1'b0;
    logic acq_busy;
    logic [7:0] low_result;
    logic meas_done;

    int n_chk = 0;
    int n_bad = 0;
    int last_res = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sync_low_timer #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .hsync_in(hsync_in), .flyback_in(flyback_in),
        .acq_wr(acq_wr), .acq_wdata(acq_wdata),
        .acq_busy(acq_busy), .low_result(low_result), .meas_done(meas_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_res(input int len);
        int dec = (len - 1) / DIV;
        return (dec >= 255) ? 0 : 255 - dec;
    endfunction

    task automatic set_sel_line(input bit sel, input bit v);
        if (sel) flyback_in = v; else hsync_in = v;
    endtask

    task automatic set_other_line(input bit sel, input bit v);
        if (sel) hsync_in = v; else flyback_in = v;
    endtask

    task automatic write_acq(input bit v);
        @(negedge clk);
        acq_wr = 1'b1; acq_wdata = v;
        @(negedge clk);
        acq_wr = 1'b0; acq_wdata = 1'b0;
    endtask

    task automatic measure(input bit sel, input int len, input bit partial, input bit midw);
        int exp = expect_res(len);
        bit oth = 1'b1;
        @(negedge clk);
        hsync_in = 1'b1; flyback_in = 1'b1; src_sel = sel;
        repeat (4) @(negedge clk);
        if (partial) begin
            set_sel_line(sel, 1'b0);
            repeat (5) @(negedge clk);
        end
        write_acq(1'b1);
        chk(acq_busy == 1'b1, "R2 busy after write", int'(acq_busy), 1);
        if (partial) begin
            repeat (6) @(negedge clk);
            set_sel_line(sel, 1'b1);
            repeat (6) @(negedge clk);
            chk(acq_busy == 1'b1, "R3 partial low ignored", int'(acq_busy), 1);
        end
        set_sel_line(sel, 1'b0);
        for (int i = 0; i < len; i++) begin
            oth = ~oth;
            set_other_line(sel, oth);
            acq_wr = (midw && i == len / 2);
            acq_wdata = acq_wr;
            @(negedge clk);
            acq_wr = 1'b0; acq_wdata = 1'b0;
        end
        set_sel_line(sel, 1'b1);
        set_other_line(sel, 1'b1);
        repeat (2) @(negedge clk);
        chk(acq_busy == 1'b1, "R6 busy before third edge", int'(acq_busy), 1);
        @(negedge clk);
        chk(acq_busy == 1'b0, "R6 busy clear", int'(acq_busy), 0);
        chk(meas_done == 1'b1, "R6 done pulse", int'(meas_done), 1);
        if (exp == 0)
            chk(low_result == 8'd0, "R5 saturated result", int'(low_result), 0);
        else if (midw)
            chk(int'(low_result) == exp, "R9 write 1 while busy", int'(low_result), exp);
        else if (sel)
            chk(int'(low_result) == exp, "R7 R4 flyback result", int'(low_result), exp);
        else
            chk(int'(low_result) == exp, "R4 sync result", int'(low_result), exp);
        @(negedge clk);
        chk(meas_done == 1'b0, "R6 done one cycle", int'(meas_done), 0);
        last_res = exp;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(acq_busy == 1'b0, "R1 busy reset", int'(acq_busy), 0);
        chk(low_result == 8'd0, "R1 result reset", int'(low_result), 0);
        chk(meas_done == 1'b0, "R1 done reset", int'(meas_done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11: idle write of 0 and idle pulses
        write_acq(1'b0);
        chk(acq_busy == 1'b0, "R11 idle write 0", int'(acq_busy), 0);
        hsync_in = 1'b0;
        repeat (5) @(negedge clk);
        hsync_in = 1'b1;
        repeat (5) @(negedge clk);
        chk(acq_busy == 1'b0 && low_result == 8'd0, "R11 idle edges", int'(acq_busy), 0);

        for (int len = 1; len <= 40; len++) measure(len[0], len, 1'b0, 1'b0);
        for (int len = 41; len <= 700; len += 13) measure(len[1], len, 1'b0, 1'b0);
        measure(1'b0, 509, 1'b0, 1'b0);
        measure(1'b1, 510, 1'b0, 1'b0);
        measure(1'b0, 511, 1'b0, 1'b0);
        measure(1'b1, 512, 1'b0, 1'b0);
        measure(1'b0, 900, 1'b0, 1'b0);
        measure(1'b0, 33, 1'b1, 1'b0);
        measure(1'b1, 47, 1'b1, 1'b0);
        measure(1'b1, 60, 1'b0, 1'b1);

        // R8: abort during COUNT
        measure(1'b0, 20, 1'b0, 1'b0);
        write_acq(1'b1);
        hsync_in = 1'b0;
        repeat (10) @(negedge clk);
        write_acq(1'b0);
        chk(acq_busy == 1'b0, "R8 abort clears busy", int'(acq_busy), 0);
        chk(meas_done == 1'b0, "R8 no done on abort", int'(meas_done), 0);
        hsync_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(meas_done == 1'b0 && int'(low_result) == last_res,
                "R8 result kept after abort", int'(low_result), last_res);
        end

        // R8: abort during ARM, later pulse is ignored
        write_acq(1'b1);
        repeat (2) @(negedge clk);
        write_acq(1'b0);
        chk(acq_busy == 1'b0, "R8 abort while armed", int'(acq_busy), 0);
        hsync_in = 1'b0;
        repeat (8) @(negedge clk);
        hsync_in = 1'b1;
        repeat (6) @(negedge clk);
        chk(int'(low_result) == last_res && acq_busy == 1'b0,
            "R8 R11 no measurement after abort", int'(low_result), last_res);

        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule